// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a memory-mapped bank of single-bit mutual-exclusion flags. Several processors share it to arbitrate common resources. Each flag sits in its own 32-bit word. A processor claims a flag by reading its word. If the read returns 0, the flag was free and the same access has just marked it taken, so the caller now owns it. If the read returns 1, another agent holds the flag and the caller should wait briefly (a few tens of nanoseconds) before trying again. The owner frees the flag by writing zero to the same word. The hardware keeps no queue of waiters and does not track who owns a flag.

A read-only status word tells software how many flags the instance provides, as a code that multiplies 32. The bus is a plain synchronous register interface with one byte address, separate read and write strobes, write data and registered read data. The number of flags is a parameter: 32, 64, 128 or 256.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every flag is free and `rd_data` is 0.
- R2: A read of a free flag returns 0 in bit 0, with all other bits 0, and marks that flag taken on the same clock edge that captures the read.
- R3: A read of a taken flag returns 1 in bit 0, with all other bits 0, and leaves the flag taken.
- R4: A write of the 32-bit value 0 to a flag word frees that flag, so the next read of it returns 0.
- R5: A write of any nonzero value to a flag word has no effect on any flag.
- R6: Flag i is at byte address 0x800 + 4*i. An access to one flag leaves every other flag unchanged.
- R7: The status word at byte address 0x14 holds NUM_LOCKS/32 in bits [27:24], which gives 2 for the default of 64 flags, so the word reads 0x0200_0000. All other bits of the status word are 0, and writes to it are ignored.
- R8: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped means any address that is neither the status word nor a word-aligned flag address, and this includes unaligned addresses inside the flag range.
- R9: Read data appears on `rd_data` in the cycle after the read strobe. In any cycle that follows a cycle with no accepted read, `rd_data` is 0.
- R10: When `rd_en` and `wr_en` are both high in the same cycle, only the write is performed. The read is dropped: it sets no flag, and `rd_data` is 0 in the next cycle.
- R11: The highest flag, at address 0x800 + 4*(NUM_LOCKS-1), works like every other flag. The word just above it is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Byte address of the access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
Two things can fall in the same cycle: a read that acquires a flag and a write that releases one, because both strobes can be high together. The bench drives both strobes high on a taken flag with a write of zero. It then checks that `rd_data` is 0 in the next cycle and that a separate follow-up read finds the flag free, which shows the write took effect and the dropped read did not set the flag again. It also runs the same collision with a nonzero write on a free flag, and a follow-up read must find that flag still free.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FLAG_BASE  = 32'h0000_0800;
  localparam int unsigned STAT_ADDR  = 32'h0000_0014;
  localparam int unsigned CODE_LSB   = 24;
  localparam int unsigned LOCKS_UNIT = 32;

  // Count code published in the status word: number of 32-flag groups.
  function automatic logic [3:0] count_code(input int unsigned n_locks);
    return 4'(n_locks / LOCKS_UNIT);
  endfunction

  // Full status word with the code at its field position.
  function automatic logic [WORD_W-1:0] status_word(input int unsigned n_locks);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CODE_LSB +: 4] = count_code(n_locks);
    return w;
  endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              flag_hit,
  output logic              stat_hit,
  output logic [IDX_W-1:0]  flag_idx
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FLAG_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(4 * NUM_LOCKS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - BASE_A;
    flag_hit = (addr >= BASE_A) && (offset < SPAN_A) && (addr[1:0] == 2'b00);
    stat_hit = (addr == STAT_A);
    flag_idx = offset[IDX_W+1:2];
  end

  always_comb begin
    AST_HIT_EXCLUSIVE: assert (!(flag_hit && stat_hit)); // R8
  end

endmodule

// File: rtl/hwlock_flags.sv
module hwlock_flags #(
  parameter int unsigned NUM_LOCKS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LOCKS-1:0] set_vec,
  input  logic [NUM_LOCKS-1:0] clr_vec,
  output logic [NUM_LOCKS-1:0] flags_q
);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_q[g] <= 1'b0;
      else if (set_vec[g]) flags_q[g] <= 1'b1;
      else if (clr_vec[g]) flags_q[g] <= 1'b0;
    end
  end

  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec | clr_vec)); // R6

  AST_OTHERS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec | clr_vec) == '0) |=> $stable(flags_q)); // R5

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);

  logic                 flag_hit;
  logic                 stat_hit;
  logic [IDX_W-1:0]     flag_idx;
  logic                 rd_take;
  logic                 acquire_ev;
  logic                 release_ev;
  logic [NUM_LOCKS-1:0] set_vec;
  logic [NUM_LOCKS-1:0] clr_vec;
  logic [NUM_LOCKS-1:0] flags_q;
  logic [31:0]          rd_next;

  hwlock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_decode (
    .addr     (addr),
    .flag_hit (flag_hit),
    .stat_hit (stat_hit),
    .flag_idx (flag_idx)
  );

  // One access per cycle: a write beats a read in the same cycle.
  always_comb begin
    rd_take    = rd_en && !wr_en;
    acquire_ev = rd_take && flag_hit;
    release_ev = wr_en && flag_hit && (wr_data == 32'd0);
    set_vec    = '0;
    clr_vec    = '0;
    if (acquire_ev) set_vec[flag_idx] = 1'b1;
    if (release_ev) clr_vec[flag_idx] = 1'b1;
  end

  hwlock_flags #(.NUM_LOCKS(NUM_LOCKS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  always_comb begin
    rd_next = '0;
    if (rd_take) begin
      if (stat_hit)      rd_next = status_word(NUM_LOCKS);
      else if (flag_hit) rd_next = {31'd0, flags_q[flag_idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  AST_ACQUIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    acquire_ev |=> flags_q[$past(flag_idx)]); // R2

  AST_FREE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acquire_ev && !flags_q[flag_idx]) |=> (rd_data == 32'd0)); // R2

  AST_TAKEN_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acquire_ev && flags_q[flag_idx]) |=> (rd_data == 32'd1)); // R3

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !flags_q[$past(flag_idx)]); // R4

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> (rd_data == 32'd0)); // R9

  AST_COLLIDE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> (rd_data == 32'd0)); // R10

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_hit && !stat_hit) |=> ((rd_data == 32'd0) && $stable(flags_q))); // R8

endmodule

// File: tb/hwlock_bank_tb_top.sv
module hwlock_bank_tb_top;

  localparam int N  = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hwlock_bank #(.NUM_LOCKS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [AW-1:0] lock_addr(input int i);
    return AW'(2048 + i * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rd_data at reset", rd_data, 32'd0);
    for (int i = 0; i < N; i++) begin
      do_read(lock_addr(i), d);
      check("R1 flag free after reset", d, 32'd0);
    end
    for (int i = 0; i < N; i++) do_write(lock_addr(i), 32'd0);
  endtask

  task automatic t_acquire_release;
    logic [31:0] d;
    do_read(lock_addr(5), d);  check("R2 free read", d, 32'd0);
    do_read(lock_addr(5), d);  check("R3 taken read", d, 32'd1);
    do_read(lock_addr(5), d);  check("R3 stays taken", d, 32'd1);
    do_write(lock_addr(5), 32'd0);
    do_read(lock_addr(5), d);  check("R4 freed", d, 32'd0);
    do_write(lock_addr(5), 32'd0);
  endtask

  task automatic t_nonzero_write;
    logic [31:0] d;
    do_read(lock_addr(9), d);
    do_write(lock_addr(9), 32'd1);
    do_write(lock_addr(9), 32'h8000_0000);
    do_read(lock_addr(9), d);  check("R5 nonzero write ignored (taken)", d, 32'd1);
    do_write(lock_addr(9), 32'd0);
    do_write(lock_addr(10), 32'hFFFF_FFFF);
    do_read(lock_addr(10), d); check("R5 nonzero write ignored (free)", d, 32'd0);
    do_write(lock_addr(10), 32'd0);
  endtask

  task automatic t_independent;
    logic [31:0] d;
    do_read(lock_addr(20), d);
    do_read(lock_addr(21), d); check("R6 neighbour untouched by acquire", d, 32'd0);
    do_read(lock_addr(19), d); check("R6 lower neighbour untouched", d, 32'd0);
    do_write(lock_addr(21), 32'd0);
    do_read(lock_addr(20), d); check("R6 release of other kept lock", d, 32'd1);
    do_write(lock_addr(20), 32'd0);
    do_write(lock_addr(19), 32'd0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    do_read(AW'(12'h014), d); check("R7 status word", d, 32'h0200_0000);
    do_write(AW'(12'h014), 32'h0);
    do_read(AW'(12'h014), d); check("R7 status write ignored", d, 32'h0200_0000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    do_read(AW'(12'h010), d); check("R8 unmapped read", d, 32'd0);
    do_read(AW'(12'h7FC), d); check("R8 below flag range", d, 32'd0);
    do_read(AW'(12'h806), d); check("R8 unaligned read", d, 32'd0);
    do_read(lock_addr(1), d); check("R8 unaligned read did not acquire", d, 32'd0);
    do_read(lock_addr(2), d);
    do_write(AW'(12'h80A), 32'd0);
    do_read(lock_addr(2), d); check("R8 unaligned write ignored", d, 32'd1);
    do_write(lock_addr(1), 32'd0);
    do_write(lock_addr(2), 32'd0);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    @(negedge clk); addr = AW'(12'h014); rd_en = 1'b1;
    check("R9 no data before edge", rd_data, 32'd0);
    @(negedge clk); rd_en = 1'b0;
    check("R9 data one cycle after", rd_data, 32'h0200_0000);
    @(negedge clk);
    check("R9 zero after idle cycle", rd_data, 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    do_read(lock_addr(30), d);
    @(negedge clk); addr = lock_addr(30); wr_data = 32'd0; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check("R10 dropped read gives zero", rd_data, 32'd0);
    do_read(lock_addr(30), d); check("R10 write won, flag free", d, 32'd0);
    do_write(lock_addr(30), 32'd0);
    @(negedge clk); addr = lock_addr(31); wr_data = 32'd7; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    do_read(lock_addr(31), d); check("R10 dropped read set nothing", d, 32'd0);
    do_write(lock_addr(31), 32'd0);
  endtask

  task automatic t_top_edge;
    logic [31:0] d;
    do_read(lock_addr(N-1), d); check("R11 top flag free read", d, 32'd0);
    do_read(lock_addr(N-1), d); check("R11 top flag taken", d, 32'd1);
    do_read(lock_addr(N), d);   check("R11 past-end word unmapped", d, 32'd0);
    do_write(lock_addr(N-1), 32'd0);
    do_read(lock_addr(N-1), d); check("R11 top flag released", d, 32'd0);
    do_write(lock_addr(N-1), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_acquire_release;
    t_nonzero_write;
    t_independent;
    t_status;
    t_unmapped;
    t_timing;
    t_collide;
    t_top_edge;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule